// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Split-Enable Condition Flags

This block pairs a combinational arithmetic-logic unit with a clocked four-bit condition flag register. Two operands and a three-bit operation code produce a result in the same cycle. The result can be an add, a subtract, a bitwise AND, a bitwise OR or a bitwise exclusive-OR.

Alongside the result the unit derives negative, zero, carry and overflow indications. These are captured into the flag register under a two-bit write enable. One enable bit covers the negative/zero pair and the other covers the carry/overflow pair. Carry and overflow exist only for the two arithmetic codes, so a logical operation can never disturb them.

A surrounding pipeline uses this to implement flag-only operations, where the result is thrown away and only the flags are kept:
- compare: subtract with both enables set;
- compare-negative: add with both enables set;
- bit test: AND with only the negative/zero enable;
- equivalence test: exclusive-OR with only the negative/zero enable.

For address arithmetic the pipeline selects add with both enables clear.

Top module: `alu_nzcv_unit`

## Requirements
- R1: `result` is combinational and follows `op_sel`: 000 gives a+b, 001 gives a-b, 010 gives a AND b, 011 gives a OR b, 100 gives a XOR b (all modulo 2^32).
- R2: Codes 101, 110 and 111 give a `result` of zero and never change the stored carry or overflow.
- R3: The flag vector is `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. N stores the most significant bit of `result`, and Z stores 1 exactly when `result` is all zeros.
- R4: For add, C is the carry out of bit 31. For subtract, computed as a + ~b + 1, C is that sum's carry out, so C=1 means no borrow.
- R5: V is 1 for add or subtract exactly when the signed result does not fit in 32 bits.
- R6: `flag_we[1]` enables the N/Z update and `flag_we[0]` enables the C/V update. A group whose enable is 0 keeps its value.
- R7: With `flag_we[0]`=1 and a logical or unused code, C and V keep their previous values.
- R8: A synchronous active-high `rst` clears all four flags on the next edge and takes priority over any write enable.
- R9: A flag update appears on `flags` in the cycle after the clock edge that sampled the enable. With `flag_we`=00 the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| flag_we | input | 2 | Bit 1: N/Z write enable, bit 0: C/V write enable |
| result | output | 32 | Combinational result |
| flags | output | 4 | Stored {N, Z, C, V} |

## Verification
The hardest state to reach is a carry/overflow pair that holds non-zero values while the other group is being rewritten, followed by a logical or unused operation with the carry/overflow enable set. Only that sequence shows whether the arithmetic gating of the carry/overflow pair really exists. Directed stimulus first forces carry and overflow to 1 with a signed-overflowing add, then issues every logical and unused code with both enables high. After that, long random runs mix the enable patterns and operation codes against a behavioural model that checks the flags on every cycle.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } nzcv_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] res,
  output nzcv_t        nzcv,
  output logic         is_arith
);
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;

  alu_addsub #(.W(W)) u_addsub (
    .a    (a),
    .b    (b),
    .sub  (sel == OP_SUB),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  always_comb begin
    is_arith = (sel == OP_ADD) || (sel == OP_SUB);
    unique case (sel)
      OP_ADD, OP_SUB: res = sum;
      OP_AND:         res = a & b;
      OP_OR:          res = a | b;
      OP_XOR:         res = a ^ b;
      default:        res = '0;
    endcase
    nzcv.neg   = res[W-1];
    nzcv.zero  = (res == '0);
    nzcv.carry = is_arith & cout;
    nzcv.ovf   = is_arith & ovf;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_nzcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] we,
  input  logic       arith,
  input  nzcv_t      next,
  output nzcv_t      q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (we[1]) begin
        q.neg  <= next.neg;
        q.zero <= next.zero;
      end
      if (we[0] && arith) begin
        q.carry <= next.carry;
        q.ovf   <= next.ovf;
      end
    end
  end
endmodule

// File: rtl/alu_nzcv_unit.sv
module alu_nzcv_unit
  import alu_nzcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic [1:0]   flag_we,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  nzcv_t nzcv_next;
  nzcv_t nzcv_q;
  logic  arith;

  alu_datapath #(.W(W)) u_dp (
    .a        (op_a),
    .b        (op_b),
    .sel      (op_sel),
    .res      (result),
    .nzcv     (nzcv_next),
    .is_arith (arith)
  );

  alu_flag_reg u_flags (
    .clk   (clk),
    .rst   (rst),
    .we    (flag_we),
    .arith (arith),
    .next  (nzcv_next),
    .q     (nzcv_q)
  );

  assign flags = nzcv_q;
endmodule

// File: rtl/alu_nzcv_checker.sv
module alu_nzcv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   op_sel,
  input logic [1:0]   flag_we,
  input logic [W-1:0] result,
  input logic [3:0]   flags
);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> flags == 4'b0000);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 3'd4) |-> result == '0);

  assert_nz_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !flag_we[1] |=> flags[3:2] == $past(flags[3:2]));

  assert_cv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !flag_we[0] |=> flags[1:0] == $past(flags[1:0]));

  assert_logic_keeps_cv_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 3'd1) |=> flags[1:0] == $past(flags[1:0]));

  assert_neg_tracks_msb_R3: assert property (@(posedge clk) disable iff (rst)
    flag_we[1] |=> flags[3] == $past(result[W-1]));

  assert_zero_tracks_result_R3: assert property (@(posedge clk) disable iff (rst)
    flag_we[1] |=> flags[2] == ($past(result) == '0));

  assert_no_write_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_we == 2'b00) |=> $stable(flags));
endmodule

bind alu_nzcv_unit alu_nzcv_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .op_sel  (op_sel),
  .flag_we (flag_we),
  .result  (result),
  .flags   (flags)
);

// File: tb/tb_alu_nzcv_unit.sv
`timescale 1ns/1ps
module tb_alu_nzcv_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_a, op_b, result;
  logic [2:0]  op_sel;
  logic [1:0]  flag_we;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model_flags;
  string last_tag;

  alu_nzcv_unit dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .flag_we(flag_we), .result(result), .flags(flags)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_result(logic [31:0] a, logic [31:0] b, logic [2:0] s);
    case (s)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic r, logic [31:0] a, logic [31:0] b,
                      logic [2:0] s, logic [1:0] we, string tag);
    logic [31:0] er;
    longint sa, sb, sr;
    logic [32:0] wide;
    logic c, v;
    @(negedge clk);
    check({"flags after ", last_tag}, {28'd0, flags}, {28'd0, model_flags});
    rst = r; op_a = a; op_b = b; op_sel = s; flag_we = we;
    #1;
    er = exp_result(a, b, s);
    if (!r) check({"result ", tag, " R1/R2"}, result, er);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (s == 3'd0) begin
      wide = {1'b0, a} + {1'b0, b};
      sr = sa + sb;
    end else begin
      wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
      sr = sa - sb;
    end
    c = wide[32];
    v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    if (r) model_flags = 4'b0000;
    else begin
      if (we[1]) model_flags[3:2] = {er[31], er == 32'd0};
      if (we[0] && s < 3'd2) model_flags[1:0] = {c, v};
    end
    last_tag = tag;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; op_sel = '0; flag_we = '0;
    model_flags = '0; last_tag = "reset R8";
    repeat (3) @(posedge clk);
    step(1'b0, 32'd0, 32'd0, 3'd0, 2'b00, "R8 reset state");
    step(1'b0, 32'hFFFF_FFFF, 32'd1, 3'd0, 2'b11, "R4 add carry, R3 zero");
    step(1'b0, 32'h7FFF_FFFF, 32'd1, 3'd0, 2'b11, "R5 add overflow, R3 neg");
    step(1'b0, 32'h8000_0000, 32'h8000_0000, 3'd0, 2'b11, "R4 R5 add carry+overflow");
    step(1'b0, 32'h0F0F_0000, 32'h00FF_FFFF, 3'd2, 2'b11, "R7 AND keeps C/V");
    step(1'b0, 32'h8000_0000, 32'd0, 3'd3, 2'b11, "R7 OR keeps C/V");
    step(1'b0, 32'h1234_5678, 32'h1234_5678, 3'd4, 2'b11, "R7 XOR keeps C/V");
    step(1'b0, 32'hDEAD_BEEF, 32'h1, 3'd5, 2'b11, "R2 code 5");
    step(1'b0, 32'hDEAD_BEEF, 32'h1, 3'd6, 2'b11, "R2 code 6");
    step(1'b0, 32'hDEAD_BEEF, 32'h1, 3'd7, 2'b11, "R2 code 7");
    step(1'b0, 32'd5, 32'd5, 3'd1, 2'b11, "R4 sub equal no borrow");
    step(1'b0, 32'd3, 32'd5, 3'd1, 2'b11, "R4 sub borrow");
    step(1'b0, 32'h8000_0000, 32'd1, 3'd1, 2'b11, "R5 sub overflow");
    step(1'b0, 32'd1, 32'd1, 3'd0, 2'b01, "R6 only C/V");
    step(1'b0, 32'hFFFF_FFFF, 32'd0, 3'd0, 2'b10, "R6 only N/Z");
    step(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd0, 2'b00, "R9 no write hold");
    step(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd0, 2'b11, "R8 reset over enable");
    step(1'b0, 32'd0, 32'd0, 3'd0, 2'b00, "R8 after reset");
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 49) == 0, $urandom, ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
           3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "random R1 R3 R4 R5 R6 R7 R9");
    end
    step(1'b0, 32'd0, 32'd0, 3'd0, 2'b00, "final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule